// File: doc/BRIEF.md
# Data Access Fault Checker

This block sits behind the data TLB lookup of a memory-management unit. For each data access it weighs the processor mode (privileged, hyperprivileged, red state, translation disabled), the class bits of the address space identifier (ASI) the access uses, and the attributes of the matched translation entry. For every request it answers with exactly one outcome. That outcome is either a physical address with a cacheability flag, or a single fault with a status cause, the context type and context number to log, and whether the access was treated as real.

Faults follow a fixed priority chain. ASI privilege violations come first. Misalignment and virtual-address range follow. Then comes the hyperprivileged bypass, which skips translation. The entry-based checks come last: miss, write protection, no-fault-only pages, and side-effect pages. The request and the TLB result arrive together. The response is registered and appears on the following cycle with a valid strobe.

Top module: `dmmu_fault_chk`

## Requirements
- R1: The response appears exactly one cycle after `req_valid`. `rsp_fault` is one-hot or zero, using bit 0 privileged action, bit 1 data-access exception, bit 2 misalignment, bit 3 TLB miss and bit 4 write protection. It is zero whenever `rsp_valid` is low.
- R2: An explicit access made with neither privilege nor hyperprivilege through a restricted ASI raises the privileged-action fault. It logs cause 1 (illegal ASI), context type 2 (nucleus) and context 0. This fault outranks all others.
- R3: An explicit access through a hyperprivilege-only ASI made without hyperprivilege raises a data-access exception with cause 1. It logs context type 2 and context 0.
- R4: A misaligned access that passes R2 and R3 raises the misalignment fault with cause 2. This holds whatever the address range and the TLB result.
- R5: A virtual address whose bits from `VA_IMPL-1` upward are not all equal raises a data-access exception with cause 3.
- R6: The context comes from the ASI selector, where 0 or 3 means primary (type 0), 1 means secondary (type 1) and 2 means nucleus (type 2, context 0). An access is real, with context forced to 0, when translation is disabled and the processor is neither hyperprivileged nor in red state. An access through a real ASI is also real.
- R7: A hyperprivileged access bypasses translation if it is implicit, or if its ASI is neither as-if-user nor real. The response then carries no fault and is cacheable, and its physical address is the low `PA_W` bits of the virtual address.
- R8: A translated access without a TLB hit raises the miss fault with cause 0.
- R9: A write to a hit entry that is not writable raises the protection fault with cause 2.
- R10: A hit entry marked no-fault-only, accessed without a no-fault ASI, raises a data-access exception with cause 4. A side-effect entry accessed with a no-fault ASI raises one with cause 5. Protection (R9) outranks both.
- R11: A successful translated access returns the TLB physical address. It is marked uncacheable when the entry has side effects or physical-address bit `PA_UC_BIT` (39) is set. A faulting access returns address 0 and is cacheable.
- R12: An implicit access skips the R2 and R3 checks and always uses the primary context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | Access is a store |
| req_misaligned | input | 1 | Alignment error flag |
| mode_priv | input | 1 | Privileged mode |
| mode_hpriv | input | 1 | Hyperprivileged mode |
| mode_xlat_off | input | 1 | Data translation disabled |
| mode_red | input | 1 | Red state |
| asi_implicit | input | 1 | Access uses the implicit ASI |
| asi_restricted | input | 1 | ASI not usable without privilege |
| asi_hpriv_only | input | 1 | ASI usable only with hyperprivilege |
| asi_real | input | 1 | Real (untranslated-context) ASI |
| asi_as_if_user | input | 1 | As-if-user ASI |
| asi_no_fault | input | 1 | No-fault ASI |
| asi_ctx_sel | input | 2 | Context selector: 0 primary, 1 secondary, 2 nucleus, 3 primary |
| ctx_primary | input | CTX_W | Primary context number |
| ctx_secondary | input | CTX_W | Secondary context number |
| tlb_hit | input | 1 | TLB lookup hit |
| tlb_writable | input | 1 | Entry writable |
| tlb_nfo | input | 1 | Entry no-fault-only |
| tlb_side_effect | input | 1 | Entry has side effects |
| tlb_pa | input | PA_W | Entry physical address |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 5 | One-hot fault vector |
| rsp_cause | output | 3 | Status cause code |
| rsp_ctx_type | output | 2 | Logged context type |
| rsp_ctx | output | CTX_W | Logged context number |
| rsp_real | output | 1 | Access treated as real |
| rsp_bypass | output | 1 | Translation bypassed |
| rsp_pa | output | PA_W | Physical address |
| rsp_uncacheable | output | 1 | Access is uncacheable |

## Verification
The main stimulus is a set of accesses that raise two or three fault conditions at once. Examples are a restricted ASI together with misalignment, misalignment on an out-of-range address, and a read-only page that is also no-fault-only. Each of these shows whether the design honours the priority order rather than just detecting each condition. Single-condition accesses separate the cause codes and the fault bit positions. Bypass addresses with bit 39 set separate the bypass path from the translated path's cacheability rule. Context cases cover every selector value and the real-access conditions in red state and under hyperprivilege, so that a mixed-up context source or a wrong real condition shows up in the logged fields.

// File: rtl/dmmu_pkg.sv
package dmmu_pkg;
    localparam int FLT_W    = 5;
    localparam int FB_PRIV  = 0;
    localparam int FB_DAE   = 1;
    localparam int FB_ALIGN = 2;
    localparam int FB_MISS  = 3;
    localparam int FB_PROT  = 4;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_ILL_ASI  = 3'd1,
        CAUSE_OTHER    = 3'd2,
        CAUSE_VA_RANGE = 3'd3,
        CAUSE_NFO      = 3'd4,
        CAUSE_SIDE_EFF = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        CT_PRI = 2'd0,
        CT_SEC = 2'd1,
        CT_NUC = 2'd2
    } ctx_type_e;
endpackage

// File: rtl/dmmu_mode_dec.sv
module dmmu_mode_dec
    import dmmu_pkg::*;
#(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 48,
    parameter int CTX_W   = 13
) (
    input  logic [VA_W-1:0]  va,
    input  logic             priv,
    input  logic             hpriv,
    input  logic             xlat_off,
    input  logic             red,
    input  logic             implicit_asi,
    input  logic             restricted,
    input  logic             hpriv_only,
    input  logic             real_asi,
    input  logic             as_if_user,
    input  logic [1:0]       ctx_sel,
    input  logic [CTX_W-1:0] pri_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    output logic             priv_act,
    output logic             hpo_viol,
    output logic             va_bad,
    output logic             real_acc,
    output logic             bypass,
    output ctx_type_e        ctx_type,
    output logic [CTX_W-1:0] ctx
);
    localparam int HI_W = VA_W - VA_IMPL + 1;

    generate
        if (VA_IMPL >= VA_W) begin : g_full_va
            assign va_bad = 1'b0;
        end else begin : g_hole_va
            logic [HI_W-1:0] va_hi;
            assign va_hi  = va[VA_W-1:VA_IMPL-1];
            assign va_bad = !((va_hi == '0) || (va_hi == '1));
        end
    endgenerate

    assign priv_act = !implicit_asi && !priv && !hpriv && restricted;
    assign hpo_viol = !implicit_asi && !hpriv && hpriv_only;
    assign real_acc = (xlat_off && !hpriv && !red) || real_asi;
    assign bypass   = hpriv && (implicit_asi || (!as_if_user && !real_asi));

    always_comb begin
        ctx_type = CT_PRI;
        ctx      = pri_ctx;
        if (!implicit_asi) begin
            unique case (ctx_sel)
                2'd1: begin
                    ctx_type = CT_SEC;
                    ctx      = sec_ctx;
                end
                2'd2: begin
                    ctx_type = CT_NUC;
                    ctx      = '0;
                end
                default: begin
                    ctx_type = CT_PRI;
                    ctx      = pri_ctx;
                end
            endcase
        end
        if (real_acc) begin
            ctx = '0;
        end
    end
endmodule

// File: rtl/dmmu_attr_chk.sv
module dmmu_attr_chk #(
    parameter int PA_W      = 40,
    parameter int PA_UC_BIT = 39
) (
    input  logic            write,
    input  logic            no_fault_asi,
    input  logic            hit,
    input  logic            writable,
    input  logic            nfo,
    input  logic            side_effect,
    input  logic [PA_W-1:0] pa,
    output logic            miss,
    output logic            prot,
    output logic            nfo_bad,
    output logic            se_bad,
    output logic            uncacheable
);
    assign miss        = !hit;
    assign prot        = write && !writable;
    assign nfo_bad     = nfo && !no_fault_asi;
    assign se_bad      = side_effect && no_fault_asi;
    assign uncacheable = side_effect || pa[PA_UC_BIT];
endmodule

// File: rtl/dmmu_fault_chk.sv
module dmmu_fault_chk
    import dmmu_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VA_IMPL   = 48,
    parameter int PA_W      = 40,
    parameter int PA_UC_BIT = 39,
    parameter int CTX_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_misaligned,
    input  logic             mode_priv,
    input  logic             mode_hpriv,
    input  logic             mode_xlat_off,
    input  logic             mode_red,
    input  logic             asi_implicit,
    input  logic             asi_restricted,
    input  logic             asi_hpriv_only,
    input  logic             asi_real,
    input  logic             asi_as_if_user,
    input  logic             asi_no_fault,
    input  logic [1:0]       asi_ctx_sel,
    input  logic [CTX_W-1:0] ctx_primary,
    input  logic [CTX_W-1:0] ctx_secondary,
    input  logic             tlb_hit,
    input  logic             tlb_writable,
    input  logic             tlb_nfo,
    input  logic             tlb_side_effect,
    input  logic [PA_W-1:0]  tlb_pa,
    output logic             rsp_valid,
    output logic [4:0]       rsp_fault,
    output logic [2:0]       rsp_cause,
    output logic [1:0]       rsp_ctx_type,
    output logic [CTX_W-1:0] rsp_ctx,
    output logic             rsp_real,
    output logic             rsp_bypass,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_uncacheable
);
    typedef struct packed {
        logic             vld;
        logic [FLT_W-1:0] fault;
        cause_e           cause;
        ctx_type_e        ctype;
        logic [CTX_W-1:0] ctx;
        logic             is_real;
        logic             byp;
        logic [PA_W-1:0]  pa;
        logic             uc;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             priv_act, hpo_viol, va_bad, real_acc, bypass;
    ctx_type_e        ctx_type;
    logic [CTX_W-1:0] ctx;
    logic             miss, prot, nfo_bad, se_bad, pa_uc;

    dmmu_mode_dec #(
        .VA_W   (VA_W),
        .VA_IMPL(VA_IMPL),
        .CTX_W  (CTX_W)
    ) u_mode_dec (
        .va          (req_va),
        .priv        (mode_priv),
        .hpriv       (mode_hpriv),
        .xlat_off    (mode_xlat_off),
        .red         (mode_red),
        .implicit_asi(asi_implicit),
        .restricted  (asi_restricted),
        .hpriv_only  (asi_hpriv_only),
        .real_asi    (asi_real),
        .as_if_user  (asi_as_if_user),
        .ctx_sel     (asi_ctx_sel),
        .pri_ctx     (ctx_primary),
        .sec_ctx     (ctx_secondary),
        .priv_act    (priv_act),
        .hpo_viol    (hpo_viol),
        .va_bad      (va_bad),
        .real_acc    (real_acc),
        .bypass      (bypass),
        .ctx_type    (ctx_type),
        .ctx         (ctx)
    );

    dmmu_attr_chk #(
        .PA_W     (PA_W),
        .PA_UC_BIT(PA_UC_BIT)
    ) u_attr_chk (
        .write       (req_write),
        .no_fault_asi(asi_no_fault),
        .hit         (tlb_hit),
        .writable    (tlb_writable),
        .nfo         (tlb_nfo),
        .side_effect (tlb_side_effect),
        .pa          (tlb_pa),
        .miss        (miss),
        .prot        (prot),
        .nfo_bad     (nfo_bad),
        .se_bad      (se_bad),
        .uncacheable (pa_uc)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.vld     = 1'b1;
            rsp_d.ctype   = ctx_type;
            rsp_d.ctx     = ctx;
            rsp_d.is_real = real_acc;
            if (priv_act) begin
                rsp_d.fault[FB_PRIV] = 1'b1;
                rsp_d.cause          = CAUSE_ILL_ASI;
                rsp_d.ctype          = CT_NUC;
                rsp_d.ctx            = '0;
            end else if (hpo_viol) begin
                rsp_d.fault[FB_DAE] = 1'b1;
                rsp_d.cause         = CAUSE_ILL_ASI;
                rsp_d.ctype         = CT_NUC;
                rsp_d.ctx           = '0;
            end else if (req_misaligned) begin
                rsp_d.fault[FB_ALIGN] = 1'b1;
                rsp_d.cause           = CAUSE_OTHER;
            end else if (va_bad) begin
                rsp_d.fault[FB_DAE] = 1'b1;
                rsp_d.cause         = CAUSE_VA_RANGE;
            end else if (bypass) begin
                rsp_d.byp = 1'b1;
                rsp_d.pa  = req_va[PA_W-1:0];
            end else if (miss) begin
                rsp_d.fault[FB_MISS] = 1'b1;
                rsp_d.cause          = CAUSE_NONE;
            end else if (prot) begin
                rsp_d.fault[FB_PROT] = 1'b1;
                rsp_d.cause          = CAUSE_OTHER;
            end else if (nfo_bad) begin
                rsp_d.fault[FB_DAE] = 1'b1;
                rsp_d.cause         = CAUSE_NFO;
            end else if (se_bad) begin
                rsp_d.fault[FB_DAE] = 1'b1;
                rsp_d.cause         = CAUSE_SIDE_EFF;
            end else begin
                rsp_d.pa = tlb_pa;
                rsp_d.uc = pa_uc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid       = rsp_q.vld;
    assign rsp_fault       = rsp_q.fault;
    assign rsp_cause       = rsp_q.cause;
    assign rsp_ctx_type    = rsp_q.ctype;
    assign rsp_ctx         = rsp_q.ctx;
    assign rsp_real        = rsp_q.is_real;
    assign rsp_bypass      = rsp_q.byp;
    assign rsp_pa          = rsp_q.pa;
    assign rsp_uncacheable = rsp_q.uc;
endmodule

// File: rtl/dmmu_fault_chk_sva.sv
module dmmu_fault_chk_sva #(
    parameter int VA_W  = 64,
    parameter int PA_W  = 40,
    parameter int CTX_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_va,
    input logic             req_write,
    input logic             req_misaligned,
    input logic             mode_priv,
    input logic             mode_hpriv,
    input logic             asi_implicit,
    input logic             asi_restricted,
    input logic             asi_hpriv_only,
    input logic             rsp_valid,
    input logic [4:0]       rsp_fault,
    input logic [2:0]       rsp_cause,
    input logic [1:0]       rsp_ctx_type,
    input logic [CTX_W-1:0] rsp_ctx,
    input logic             rsp_real,
    input logic             rsp_bypass,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_uncacheable
);
    AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_fault)); // R1
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == 5'd0)); // R1
    AST_PRIV_NUCLEUS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault[0] |-> (rsp_ctx_type == 2'd2 && rsp_ctx == '0 && rsp_cause == 3'd1)); // R2
    AST_ALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_misaligned &&
         (asi_implicit || ((mode_priv || mode_hpriv || !asi_restricted) &&
                           (mode_hpriv || !asi_hpriv_only))))
        |=> (rsp_fault == 5'b00100)); // R4
    AST_REAL_CTX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_real) |-> (rsp_ctx == '0)); // R6
    AST_BYPASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_bypass |-> (rsp_fault == 5'd0 && !rsp_uncacheable && rsp_valid)); // R7
    AST_PROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault[4] |-> $past(req_write)); // R9
    AST_UC_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_uncacheable |-> (rsp_valid && rsp_fault == 5'd0)); // R11
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 5'd0) |-> (rsp_pa == '0)); // R11
endmodule

bind dmmu_fault_chk dmmu_fault_chk_sva #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .CTX_W(CTX_W)
) u_sva (.*);

// File: tb/dmmu_fault_chk_bench.sv
module dmmu_fault_chk_bench;
    localparam int VA_W  = 64;
    localparam int PA_W  = 40;
    localparam int CTX_W = 13;

    localparam logic [15:0] F_WR   = 16'h0001;
    localparam logic [15:0] F_PRIV = 16'h0002;
    localparam logic [15:0] F_HPRV = 16'h0004;
    localparam logic [15:0] F_XOFF = 16'h0008;
    localparam logic [15:0] F_RED  = 16'h0010;
    localparam logic [15:0] F_RSTR = 16'h0020;
    localparam logic [15:0] F_HPO  = 16'h0040;
    localparam logic [15:0] F_REAL = 16'h0080;
    localparam logic [15:0] F_AIU  = 16'h0100;
    localparam logic [15:0] F_NF   = 16'h0200;
    localparam logic [15:0] F_IMPL = 16'h0400;
    localparam logic [15:0] F_MIS  = 16'h0800;
    localparam logic [15:0] F_HIT  = 16'h1000;
    localparam logic [15:0] F_WRT  = 16'h2000;
    localparam logic [15:0] F_NFO  = 16'h4000;
    localparam logic [15:0] F_SE   = 16'h8000;

    localparam logic [CTX_W-1:0] PRI = 13'h123;
    localparam logic [CTX_W-1:0] SEC = 13'h456;

    typedef struct packed {
        logic [3:0]      req;
        logic [15:0]     fl;
        logic [63:0]     va;
        logic [39:0]     pa;
        logic [4:0]      ef;
        logic [2:0]      ec;
        logic [39:0]     epa;
        logic            euc;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd11, F_PRIV|F_HIT,               64'h1000,                40'h2000,         5'b00000, 3'd0, 40'h2000,         1'b0}, // R11 plain hit
        '{4'd2,  F_RSTR|F_HIT,               64'h1000,                40'h2000,         5'b00001, 3'd1, 40'h0,            1'b0}, // R2
        '{4'd3,  F_PRIV|F_HPO|F_HIT,         64'h1000,                40'h2000,         5'b00010, 3'd1, 40'h0,            1'b0}, // R3
        '{4'd2,  F_RSTR|F_MIS|F_HIT,         64'h1001,                40'h2000,         5'b00001, 3'd1, 40'h0,            1'b0}, // R2 over R4
        '{4'd4,  F_PRIV|F_MIS|F_HIT,         64'h0000_8000_0000_0001, 40'h2000,         5'b00100, 3'd2, 40'h0,            1'b0}, // R4 over R5
        '{4'd5,  F_PRIV|F_HIT,               64'h0000_8000_0000_0000, 40'h2000,         5'b00010, 3'd3, 40'h0,            1'b0}, // R5
        '{4'd5,  F_PRIV|F_HIT,               64'hFFFF_8000_0000_1000, 40'h3000,         5'b00000, 3'd0, 40'h3000,         1'b0}, // R5 upper hole ok
        '{4'd7,  F_HPRV,                     64'h0000_7FAB_CDEF_1234, 40'h0,            5'b00000, 3'd0, 40'hAB_CDEF_1234, 1'b0}, // R7
        '{4'd8,  F_HPRV|F_AIU,               64'h1000,                40'h2000,         5'b01000, 3'd0, 40'h0,            1'b0}, // R8
        '{4'd9,  F_PRIV|F_WR|F_HIT,          64'h1000,                40'h2000,         5'b10000, 3'd2, 40'h0,            1'b0}, // R9
        '{4'd9,  F_PRIV|F_WR|F_HIT|F_WRT,    64'h1000,                40'h2000,         5'b00000, 3'd0, 40'h2000,         1'b0}, // R9 writable
        '{4'd10, F_PRIV|F_HIT|F_NFO,         64'h1000,                40'h2000,         5'b00010, 3'd4, 40'h0,            1'b0}, // R10 nfo
        '{4'd10, F_PRIV|F_HIT|F_NFO|F_NF,    64'h1000,                40'h2000,         5'b00000, 3'd0, 40'h2000,         1'b0}, // R10 nfo ok
        '{4'd10, F_PRIV|F_HIT|F_SE|F_NF,     64'h1000,                40'h5000,         5'b00010, 3'd5, 40'h0,            1'b0}, // R10 side effect
        '{4'd11, F_PRIV|F_HIT|F_SE,          64'h1000,                40'h5000,         5'b00000, 3'd0, 40'h5000,         1'b1}, // R11 se uc
        '{4'd11, F_PRIV|F_HIT,               64'h1000,                40'h80_0000_4000, 5'b00000, 3'd0, 40'h80_0000_4000, 1'b1}, // R11 bit39 uc
        '{4'd9,  F_PRIV|F_WR|F_HIT|F_NFO,    64'h1000,                40'h2000,         5'b10000, 3'd2, 40'h0,            1'b0}, // R9 over R10
        '{4'd12, F_IMPL|F_RSTR|F_HPO|F_HIT,  64'h1000,                40'h6000,         5'b00000, 3'd0, 40'h6000,         1'b0}, // R12
        '{4'd4,  F_PRIV|F_MIS,               64'h1001,                40'h0,            5'b00100, 3'd2, 40'h0,            1'b0}  // R4 over R8
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_va = '0;
    logic             req_write = 1'b0, req_misaligned = 1'b0;
    logic             mode_priv = 1'b0, mode_hpriv = 1'b0, mode_xlat_off = 1'b0, mode_red = 1'b0;
    logic             asi_implicit = 1'b0, asi_restricted = 1'b0, asi_hpriv_only = 1'b0;
    logic             asi_real = 1'b0, asi_as_if_user = 1'b0, asi_no_fault = 1'b0;
    logic [1:0]       asi_ctx_sel = 2'd0;
    logic [CTX_W-1:0] ctx_primary = PRI, ctx_secondary = SEC;
    logic             tlb_hit = 1'b0, tlb_writable = 1'b0, tlb_nfo = 1'b0, tlb_side_effect = 1'b0;
    logic [PA_W-1:0]  tlb_pa = '0;
    logic             rsp_valid;
    logic [4:0]       rsp_fault;
    logic [2:0]       rsp_cause;
    logic [1:0]       rsp_ctx_type;
    logic [CTX_W-1:0] rsp_ctx;
    logic             rsp_real, rsp_bypass, rsp_uncacheable;
    logic [PA_W-1:0]  rsp_pa;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dmmu_fault_chk u_dmmu_fault_chk (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] fl, input logic [63:0] va, input logic [39:0] pa,
                         input logic [1:0] sel);
        @(negedge clk);
        req_valid       = 1'b1;
        req_va          = va;
        tlb_pa          = pa;
        asi_ctx_sel     = sel;
        req_write       = |(fl & F_WR);
        mode_priv       = |(fl & F_PRIV);
        mode_hpriv      = |(fl & F_HPRV);
        mode_xlat_off   = |(fl & F_XOFF);
        mode_red        = |(fl & F_RED);
        asi_restricted  = |(fl & F_RSTR);
        asi_hpriv_only  = |(fl & F_HPO);
        asi_real        = |(fl & F_REAL);
        asi_as_if_user  = |(fl & F_AIU);
        asi_no_fault    = |(fl & F_NF);
        asi_implicit    = |(fl & F_IMPL);
        req_misaligned  = |(fl & F_MIS);
        tlb_hit         = |(fl & F_HIT);
        tlb_writable    = |(fl & F_WRT);
        tlb_nfo         = |(fl & F_NFO);
        tlb_side_effect = |(fl & F_SE);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ctx_case(input string tag, input logic [15:0] fl, input logic [1:0] sel,
                            input logic [1:0] et, input logic [12:0] ec, input logic er);
        drive(fl, 64'h1000, 40'h2000, sel);
        check({tag, " ctx_type"}, 64'(rsp_ctx_type), 64'(et));
        check({tag, " ctx"},      64'(rsp_ctx),      64'(ec));
        check({tag, " real"},     64'(rsp_real),     64'(er));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(rsp_valid), 64'd0);
        check("R1 reset fault", 64'(rsp_fault), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].fl, VECS[i].va, VECS[i].pa, 2'd0);
            check($sformatf("R1 v%0d valid", i), 64'(rsp_valid), 64'd1);
            check($sformatf("R%0d v%0d fault", VECS[i].req, i), 64'(rsp_fault), 64'(VECS[i].ef));
            check($sformatf("R%0d v%0d cause", VECS[i].req, i), 64'(rsp_cause), 64'(VECS[i].ec));
            check($sformatf("R%0d v%0d pa", VECS[i].req, i),    64'(rsp_pa),    64'(VECS[i].epa));
            check($sformatf("R%0d v%0d uc", VECS[i].req, i),    64'(rsp_uncacheable), 64'(VECS[i].euc));
        end

        // R1: idle cycle gives no response
        @(negedge clk);
        check("R1 idle valid", 64'(rsp_valid), 64'd0);
        check("R1 idle fault", 64'(rsp_fault), 64'd0);

        // R6: context selection and real accesses
        ctx_case("R6 secondary",       F_HIT,                2'd1, 2'd1, SEC,    1'b0);
        ctx_case("R6 nucleus",         F_PRIV|F_HIT,         2'd2, 2'd2, 13'd0,  1'b0);
        ctx_case("R6 sel3 primary",    F_PRIV|F_HIT,         2'd3, 2'd0, PRI,    1'b0);
        ctx_case("R6 xlat off real",   F_XOFF|F_HIT,         2'd0, 2'd0, 13'd0,  1'b1);
        ctx_case("R6 red not real",    F_PRIV|F_XOFF|F_RED|F_HIT, 2'd0, 2'd0, PRI, 1'b0);
        ctx_case("R6 hpriv not real",  F_HPRV|F_XOFF|F_AIU|F_HIT, 2'd0, 2'd0, PRI, 1'b0);
        ctx_case("R6 real asi",        F_PRIV|F_REAL|F_HIT,  2'd1, 2'd1, 13'd0,  1'b1);
        // R2 / R3: privilege faults log nucleus context
        ctx_case("R2 nucleus log",     F_RSTR|F_HIT,         2'd1, 2'd2, 13'd0,  1'b0);
        ctx_case("R3 nucleus log",     F_PRIV|F_HPO|F_HIT,   2'd1, 2'd2, 13'd0,  1'b0);
        // R12: implicit access uses primary regardless of selector
        ctx_case("R12 implicit ctx",   F_IMPL|F_HIT,         2'd1, 2'd0, PRI,    1'b0);

        // R7: hyperprivileged implicit access bypasses even with AIU set
        drive(F_HPRV|F_IMPL|F_AIU, 64'h0000_0012_3456_7890, 40'h0, 2'd0);
        check("R7 implicit bypass flag", 64'(rsp_bypass), 64'd1);
        check("R7 implicit bypass pa",   64'(rsp_pa), 64'h12_3456_7890);
        // R7: hyperprivileged real-ASI access is translated, not bypassed
        drive(F_HPRV|F_REAL|F_HIT, 64'h1000, 40'h7000, 2'd0);
        check("R7 real asi no bypass", 64'(rsp_bypass), 64'd0);
        check("R7 real asi pa",        64'(rsp_pa), 64'h7000);

        // R1: reset clears a pending response
        @(negedge clk);
        req_valid = 1'b1;
        mode_priv = 1'b1;
        tlb_hit   = 1'b1;
        @(posedge clk);
        #1 rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 reset mid valid", 64'(rsp_valid), 64'd0);
        check("R1 reset mid pa",    64'(rsp_pa), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule